// File: doc/BRIEF.md
# Folded-Table Constant Multiplier (5-bit sign-magnitude operand)

This block multiplies a 5-bit operand by a coefficient fixed at elaboration time. The operand is in sign-magnitude form: the top bit is the sign and the four lower bits are the magnitude. A full product table would need 32 words. This block uses 8 words.

The sign bit never reaches the table address. The sixteen magnitudes are then folded in pairs. Magnitudes m and 15 − m have products that sum to 15 times the coefficient. The table therefore stores only the odd multiples of the coefficient, from 15 times down to 1 time. The address is the low three magnitude bits, each XORed with the magnitude MSB. The selected word is added to, or subtracted from, the constant 15·coefficient and the result is halved exactly. The sign is applied last.

A parameter selects how the coefficient is coded, either two's complement or sign-magnitude. The product uses the same coding as the coefficient. A second parameter places an optional register on the output.

Top module: `apc_const_mult`

## Requirements
- R1: With COEF_FMT = two's complement (0), for every 5-bit input x_in the output prod_out is the COEF_W+4-bit two's-complement value of A·(−1)^x_in[4]·x_in[3:0], where A is COEF read as signed.
- R2: With COEF_FMT = sign-magnitude (1), COEF[COEF_W-1] is the coefficient sign and COEF[COEF_W-2:0] its magnitude. For every input, prod_out[COEF_W+2:0] = |A|·x_in[3:0] and prod_out[COEF_W+3] = COEF[COEF_W-1] XOR x_in[4].
- R3: For magnitudes m and 15 − m with the same sign bit, the two products sum to 15·A in the two's-complement variant. In the sign-magnitude variant, the two magnitude fields sum to 15·|A|.
- R4: In the two's-complement variant, inputs 5'b00000 (+0) and 5'b10000 (−0) both give an all-zero output.
- R5: In the sign-magnitude variant, input −0 (5'b10000) gives a zero magnitude field and a sign bit equal to COEF[COEF_W-1] XOR 1.
- R6: Magnitude 15 gives the full-scale product. Input 5'b01111 gives 15·A and input 5'b11111 gives −15·A (two's complement), or a magnitude of 15·|A| (sign-magnitude).
- R7: With OUT_REG = 1, prod_out reflects the x_in sampled at the previous rising clk edge. With OUT_REG = 0, prod_out follows x_in within the same cycle.
- R8: With OUT_REG = 1, prod_out is zero while rst_n is low, whatever the value of x_in.
- R9: The most negative two's-complement coefficient −2^(COEF_W-1), multiplied by −15, gives +15·2^(COEF_W-1) without overflow.
- R10: Bit 0 of prod_out equals COEF[0] AND x_in[0] for every input in both variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_in | input | 5 | Operand: bit 4 is the sign, bits 3:0 are the magnitude |
| prod_out | output | COEF_W+4 | Product, coded the same way as the coefficient |

## Verification
The assertions assume that x_in is fully known and steady around each rising clk edge. They also assume that the coefficient is a fixed parameter, so each compares prod_out against a reference product computed from the operand sampled at the matching edge. The stimulus changes x_in only on falling edges and drives only defined values. It runs several coefficient settings side by side: zero, one, odd and even values, both extremes, and a negative zero in sign-magnitude. The settings include one unregistered instance, so every configuration receives the same operand sequence.

// File: rtl/apc_pkg.sv
package apc_pkg;
   // operand magnitude width (the sign bit sits above it)
   localparam int MAG_W     = 4;
   localparam int X_W       = MAG_W + 1;
   // folded table: one address bit fewer than the magnitude
   localparam int TBL_AW    = MAG_W - 1;
   localparam int TBL_DEPTH = 1 << TBL_AW;
   // pair-sum multiplier: magnitudes m and FOLD_K-m pair up
   localparam int FOLD_K    = (1 << MAG_W) - 1;
   // product growth over the coefficient width
   localparam int GROW_W    = MAG_W;

   typedef enum logic {
      COEF_TWOS    = 1'b0,
      COEF_SIGNMAG = 1'b1
   } coef_fmt_e;
endpackage

// File: rtl/apc_addr_map.sv
module apc_addr_map
   import apc_pkg::*;
(
   input  logic [MAG_W-1:0]  mag_i,
   output logic [TBL_AW-1:0] addr_o,
   output logic              fold_up_o
);
   assign fold_up_o = mag_i[MAG_W-1];

   for (genvar b = 0; b < TBL_AW; b++) begin : g_fold_xor
      assign addr_o[b] = mag_i[b] ^ mag_i[MAG_W-1];
   end
endmodule

// File: rtl/apc_table.sv
module apc_table
   import apc_pkg::*;
#(
   parameter int                WORD_W = 12,
   parameter logic [WORD_W-1:0] BASE   = '0
) (
   input  logic [TBL_AW-1:0] addr_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] rom [TBL_DEPTH];

   // entry k holds the odd multiple (FOLD_K - 2k) of the base
   for (genvar k = 0; k < TBL_DEPTH; k++) begin : g_entry
      localparam logic [WORD_W-1:0] ODD   = WORD_W'(FOLD_K - 2 * k);
      localparam logic [WORD_W-1:0] ENTRY = BASE * ODD;
      assign rom[k] = ENTRY;
   end

   assign word_o = rom[addr_i];
endmodule

// File: rtl/apc_addsub_halve.sv
module apc_addsub_halve #(
   parameter int                WORD_W    = 12,
   parameter bit                SIGNED_OP = 1'b1,
   parameter logic [WORD_W-1:0] FOLD      = '0
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              fold_up_i,
   output logic [WORD_W-1:0] half_o
);
   // Both FOLD and word_i are odd multiples of the same base, so they
   // share bit 0. The halved sum is then (F>>1)+(w>>1)+lsb and the halved
   // difference is (F>>1)-(w>>1), so no wide intermediate is needed.
   localparam logic              FOLD_EXT = SIGNED_OP ? FOLD[WORD_W-1] : 1'b0;
   localparam logic [WORD_W-1:0] FOLD_HF  = {FOLD_EXT, FOLD[WORD_W-1:1]};

   logic              word_ext;
   logic [WORD_W-1:0] word_hf;
   logic [WORD_W-1:0] carry_in;

   assign word_ext = SIGNED_OP ? word_i[WORD_W-1] : 1'b0;
   assign word_hf  = {word_ext, word_i[WORD_W-1:1]};
   assign carry_in = {{(WORD_W-1){1'b0}}, word_i[0]};

   always_comb begin
      if (fold_up_i) half_o = FOLD_HF + word_hf + carry_in;
      else           half_o = FOLD_HF - word_hf;
   end
endmodule

// File: rtl/apc_sign_stage.sv
module apc_sign_stage
   import apc_pkg::*;
#(
   parameter int        PROD_W = 12,
   parameter coef_fmt_e FMT    = COEF_TWOS,
   localparam int       IN_W   = (FMT == COEF_TWOS) ? PROD_W : PROD_W - 1
) (
   input  logic [IN_W-1:0]   half_i,
   input  logic              neg_i,
   output logic [PROD_W-1:0] prod_o
);
   if (FMT == COEF_TWOS) begin : g_twos
      logic [PROD_W-1:0] negated;
      assign negated = (~half_i) + PROD_W'(1);
      assign prod_o  = neg_i ? negated : half_i;
   end else begin : g_signmag
      assign prod_o = {neg_i, half_i};
   end
endmodule

// File: rtl/apc_const_mult.sv
module apc_const_mult
   import apc_pkg::*;
#(
   parameter int                COEF_W   = 8,
   parameter logic [COEF_W-1:0] COEF     = COEF_W'(37),
   parameter coef_fmt_e         COEF_FMT = COEF_TWOS,
   parameter bit                OUT_REG  = 1'b1,
   localparam int               PROD_W   = COEF_W + GROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [X_W-1:0]    x_in,
   output logic [PROD_W-1:0] prod_out
);
   // elaboration-time parameter checks
   if (COEF_W < 2 || COEF_W > 24) begin : g_bad_width
      $error("apc_const_mult: COEF_W must lie in 2..24");
   end

   logic [TBL_AW-1:0] tbl_addr;
   logic              fold_up;
   logic              x_neg;
   logic [PROD_W-1:0] prod_comb;

   assign x_neg = x_in[X_W-1];

   apc_addr_map amap_i (
      .mag_i     (x_in[MAG_W-1:0]),
      .addr_o    (tbl_addr),
      .fold_up_o (fold_up)
   );

   if (COEF_FMT == COEF_TWOS) begin : g_twos
      localparam logic [PROD_W-1:0] BASE = {{GROW_W{COEF[COEF_W-1]}}, COEF};
      localparam logic [PROD_W-1:0] FOLD = BASE * PROD_W'(FOLD_K);

      logic [PROD_W-1:0] tbl_word;
      logic [PROD_W-1:0] half;

      apc_table #(.WORD_W(PROD_W), .BASE(BASE)) tbl_i (
         .addr_i (tbl_addr),
         .word_o (tbl_word)
      );

      apc_addsub_halve #(.WORD_W(PROD_W), .SIGNED_OP(1'b1), .FOLD(FOLD)) ash_i (
         .word_i    (tbl_word),
         .fold_up_i (fold_up),
         .half_o    (half)
      );

      apc_sign_stage #(.PROD_W(PROD_W), .FMT(COEF_TWOS)) sgn_i (
         .half_i (half),
         .neg_i  (x_neg),
         .prod_o (prod_comb)
      );
   end else begin : g_signmag
      localparam int               MW   = PROD_W - 1;
      localparam logic [MW-1:0]    BASE = {{(GROW_W){1'b0}}, COEF[COEF_W-2:0]};
      localparam logic [MW-1:0]    FOLD = BASE * MW'(FOLD_K);

      logic [MW-1:0] tbl_word;
      logic [MW-1:0] half;
      logic          prod_sign;

      assign prod_sign = COEF[COEF_W-1] ^ x_neg;

      apc_table #(.WORD_W(MW), .BASE(BASE)) tbl_i (
         .addr_i (tbl_addr),
         .word_o (tbl_word)
      );

      apc_addsub_halve #(.WORD_W(MW), .SIGNED_OP(1'b0), .FOLD(FOLD)) ash_i (
         .word_i    (tbl_word),
         .fold_up_i (fold_up),
         .half_o    (half)
      );

      apc_sign_stage #(.PROD_W(PROD_W), .FMT(COEF_SIGNMAG)) sgn_i (
         .half_i (half),
         .neg_i  (prod_sign),
         .prod_o (prod_comb)
      );
   end

   if (OUT_REG) begin : g_oreg
      logic [PROD_W-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod_q <= '0;
         else        prod_q <= prod_comb;
      end
      assign prod_out = prod_q;
   end else begin : g_comb
      assign prod_out = prod_comb;
   end
endmodule

// File: rtl/apc_const_mult_chk.sv
module apc_const_mult_chk
   import apc_pkg::*;
#(
   parameter int                COEF_W   = 8,
   parameter logic [COEF_W-1:0] COEF     = COEF_W'(37),
   parameter coef_fmt_e         COEF_FMT = COEF_TWOS,
   parameter bit                OUT_REG  = 1'b1,
   localparam int               PROD_W   = COEF_W + GROW_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [X_W-1:0]    x_in,
   input logic [PROD_W-1:0] prod_out
);
   // behavioural reference: plain integer multiply
   function automatic logic [PROD_W-1:0] ref_prod(input logic [X_W-1:0] xv);
      int m;
      int p;
      m = int'(xv[MAG_W-1:0]);
      if (COEF_FMT == COEF_TWOS) begin
         p = int'($signed(COEF)) * m;
         if (xv[X_W-1]) p = -p;
         return PROD_W'(p);
      end else begin
         p = int'(COEF[COEF_W-2:0]) * m;
         return {COEF[COEF_W-1] ^ xv[X_W-1], (PROD_W-1)'(p)};
      end
   endfunction

   logic [X_W-1:0] x_d;
   logic           v_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_d <= '0;
         v_d <= 1'b0;
      end else begin
         x_d <= x_in;
         v_d <= 1'b1;
      end
   end

   logic [X_W-1:0]    x_c;
   logic              v_c;
   logic [PROD_W-1:0] exp_c;

   assign x_c   = OUT_REG ? x_d : x_in;
   assign v_c   = OUT_REG ? v_d : 1'b1;
   assign exp_c = ref_prod(x_c);

   // R1 / R2 / R7: full product with the configured latency
   a_r1_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
      v_c |-> prod_out == exp_c);

   // R10: product parity follows the two operand LSBs
   a_r10_lsb_parity: assert property (@(posedge clk) disable iff (!rst_n)
      v_c |-> prod_out[0] == (COEF[0] & x_c[0]));

   if (COEF_FMT == COEF_TWOS) begin : g_twos_chk
      // R4: signed zero operand gives a zero product
      a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
         (v_c && x_c[MAG_W-1:0] == '0) |-> prod_out == '0);
   end else begin : g_sm_chk
      // R5: sign bit is coefficient sign XOR operand sign, even at zero
      a_r5_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
         v_c |-> prod_out[PROD_W-1] == (COEF[COEF_W-1] ^ x_c[X_W-1]));
   end

   if (OUT_REG) begin : g_reg_chk
      // R7: registered output holds while the operand holds
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (v_d && x_in == x_d) |=> $stable(prod_out));
   end
endmodule

bind apc_const_mult apc_const_mult_chk #(
   .COEF_W   (COEF_W),
   .COEF     (COEF),
   .COEF_FMT (COEF_FMT),
   .OUT_REG  (OUT_REG)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .x_in     (x_in),
   .prod_out (prod_out)
);

// File: tb/apc_const_mult_tb_top.sv
module apc_const_mult_tb_top;
   import apc_pkg::*;

   localparam int W    = 8;
   localparam int PW   = W + 4;
   localparam int NCFG = 12;
   localparam int NTWO = 6;
   localparam int GCOMB = 2;

   function automatic logic [W-1:0] coef_of(input int g);
      case (g)
         0:  return 8'h00;
         1:  return 8'h01;
         2:  return 8'h25;
         3:  return 8'h80;
         4:  return 8'h7F;
         5:  return 8'hD3;
         6:  return 8'h00;
         7:  return 8'h80;
         8:  return 8'h25;
         9:  return 8'hFF;
         10: return 8'h7F;
         default: return 8'h81;
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    x = 5'd0;
   logic [PW-1:0] prod [NCFG];

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      apc_const_mult #(
         .COEF_W   (W),
         .COEF     (coef_of(g)),
         .COEF_FMT (coef_fmt_e'(g >= NTWO)),
         .OUT_REG  (g != GCOMB)
      ) dut_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .x_in     (x),
         .prod_out (prod[g])
      );
   end

   task automatic chk(input string req, input int g, input logic [PW-1:0] act,
                      input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cfg=%0d x=%b actual=%h expected=%h", req, g, x, act, exp);
      end
   endtask

   function automatic int coef_signed(input int g);
      logic [W-1:0] c;
      c = coef_of(g);
      return int'($signed(c));
   endfunction

   function automatic int coef_mag(input int g);
      logic [W-1:0] c;
      c = coef_of(g);
      return int'(c[W-2:0]);
   endfunction

   function automatic logic coef_sign(input int g);
      logic [W-1:0] c;
      c = coef_of(g);
      return c[W-1];
   endfunction

   function automatic logic [PW-1:0] model(input int g, input logic [4:0] xv);
      int p;
      if (g < NTWO) begin
         p = coef_signed(g) * int'(xv[3:0]);
         if (xv[4]) p = -p;
         return PW'(p);
      end
      p = coef_mag(g) * int'(xv[3:0]);
      return {coef_sign(g) ^ xv[4], (PW-1)'(p)};
   endfunction

   task automatic apply(input logic [4:0] v);
      @(negedge clk);
      x = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      x = 5'h1F;
      repeat (2) @(negedge clk);
      for (int g = 0; g < NCFG; g++)
         if (g != GCOMB) chk("R8 reset", g, prod[g], '0);
      rst_n = 1'b1;
   endtask

   task automatic t_sweep();
      for (int v = 0; v < 32; v++) begin
         apply(5'(v));
         for (int g = 0; g < NCFG; g++) begin
            chk(g < NTWO ? "R1 product" : "R2 product", g, prod[g], model(g, 5'(v)));
            chk("R10 lsb", g, PW'(prod[g][0]), PW'(coef_of(g)[0] & x[0]));
         end
      end
   endtask

   task automatic t_zero();
      apply(5'b00000);
      for (int g = 0; g < NTWO; g++) chk("R4 plus zero", g, prod[g], '0);
      apply(5'b10000);
      for (int g = 0; g < NTWO; g++) chk("R4 minus zero", g, prod[g], '0);
      for (int g = NTWO; g < NCFG; g++)
         chk("R5 minus zero", g, prod[g], {~coef_sign(g), {(PW-1){1'b0}}});
   endtask

   task automatic t_mirror();
      int first [NCFG];
      int sum;
      for (int m = 0; m < 8; m++) begin
         apply(5'(m));
         for (int g = 0; g < NCFG; g++)
            first[g] = (g < NTWO) ? int'($signed(prod[g])) : int'(prod[g][PW-2:0]);
         apply(5'(15 - m));
         for (int g = 0; g < NCFG; g++) begin
            if (g < NTWO) begin
               sum = first[g] + int'($signed(prod[g]));
               chk("R3 mirror", g, PW'(sum), PW'(15 * coef_signed(g)));
            end else begin
               sum = first[g] + int'(prod[g][PW-2:0]);
               chk("R3 mirror", g, PW'(sum), PW'(15 * coef_mag(g)));
            end
         end
      end
   endtask

   task automatic t_full_scale();
      apply(5'b01111);
      for (int g = 0; g < NCFG; g++)
         chk("R6 full scale", g, prod[g],
             g < NTWO ? PW'(15 * coef_signed(g))
                      : {coef_sign(g), (PW-1)'(15 * coef_mag(g))});
      apply(5'b11111);
      for (int g = 0; g < NCFG; g++)
         chk("R6 neg full scale", g, prod[g],
             g < NTWO ? PW'(-15 * coef_signed(g))
                      : {~coef_sign(g), (PW-1)'(15 * coef_mag(g))});
      chk("R9 most negative coef", 3, prod[3], 12'h780);
   endtask

   task automatic t_latency();
      apply(5'd0);
      @(negedge clk);
      x = 5'd9;
      #1;
      chk("R7 comb same cycle", GCOMB, prod[GCOMB], 12'd333);
      chk("R7 reg holds old", 1, prod[1], 12'd0);
      @(negedge clk);
      chk("R7 reg one cycle", 1, prod[1], 12'd9);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_zero();
      t_mirror();
      t_full_scale();
      t_latency();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule